// File: doc/BRIEF.md
# Two-Digit Seconds Counter with Binary Timebase

This block is the core of a stopwatch that shows elapsed seconds from 00 to 99. It runs on a single 4,194,304 Hz clock. A chain of two power-of-two divider stages brings that rate down to one event per second. The first stage is 14 bits wide and yields a 256 Hz rate. The second stage is 8 bits wide. Each second-event advances a units decimal digit. The tens decimal digit moves on when the units digit's top bit drops, which happens only when the units digit rolls from nine back to zero.

All state lives on the fast clock. The once-per-second event and the digit carry are one-cycle enable pulses, not derived clocks. The divided level is brought out inverted so that it can drive an LED, which then blinks once a second. Counting acts on the edge where that inverted level goes low. The two stage widths are parameters, so a simulation can run with a tiny divisor while the digit sequence and the carry stay the same.

Top module: `stopwatch_core`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, both divider stages and both digits clear: after the edge `units_o` = 0, `tens_o` = 0 and `sec_led_o` = 1.
- R2: With `run` held high, `units_o` advances by one on the 2^(STAGE1_BITS+STAGE2_BITS-1)-th enabled clock after reset, and then once every 2^(STAGE1_BITS+STAGE2_BITS) enabled clocks. The defaults (14 and 8) turn 4,194,304 Hz into 1 Hz.
- R3: `units_o` is BCD and counts 0,1,...,9, then returns to 0 on the next advance. It never shows a value above 9.
- R4: `tens_o` advances by one on the clock edge that follows the edge where bit 3 of `units_o` falls from 1 to 0, which is the 9-to-0 roll. At no other time does `tens_o` change, except through reset.
- R5: `tens_o` is BCD and rolls from 9 to 0, so the pair reads 00 after 99 and counting carries on.
- R6: `sec_led_o` is the inverse of the top bit of the second divider stage. It has a 50% duty cycle, and it falls on the same clock edge on which `units_o` advances.
- R7: While `run` is low, both divider stages and `units_o` keep their values, and so does `sec_led_o`.
- R8: If `run` drops on the edge right after a 9-to-0 roll of `units_o`, the pending carry still completes: `tens_o` advances one edge after the roll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Count enable; low freezes the timebase and the units digit |
| units_o | output | 4 | Units-of-seconds BCD digit |
| tens_o | output | 4 | Tens-of-seconds BCD digit |
| sec_led_o | output | 1 | Inverted 1 Hz level for an indicator LED |

## Verification
Two events can land on neighbouring edges: the units roll with its delayed tens carry, and a drop of `run`. The bench steps the counter until the next enabled edge is certain to roll the units from 9 to 0. It lets that edge happen with `run` high and clears `run` just before the following edge. The check is that `tens_o` still advances exactly one edge after the roll while `units_o` and `sec_led_o` stay frozen. A cycle-accurate model kept in the bench is compared with every output on every clock, so a carry that is lost, doubled or mistimed shows up at once.

// File: rtl/sw_pkg.sv
package sw_pkg;
    typedef logic [3:0] bcd_t;
    localparam bcd_t BCD_TOP = 4'd9;
endpackage

// File: rtl/sw_div_stage.sv
module sw_div_stage #(
    parameter int BITS = 14
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    output logic [BITS-1:0] cnt_o,
    output logic            wrap_o,
    output logic            msb_o
);
    localparam logic [BITS-1:0] ALL_ONES = {BITS{1'b1}};

    typedef struct packed {
        logic [BITS-1:0] cnt;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign wrap_o = en && (st_q.cnt == ALL_ONES);
    assign msb_o  = st_q.cnt[BITS-1];

    // R7: a stage without enable keeps its count
    p_stage_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt_o));
endmodule

// File: rtl/sw_bcd_digit.sv
module sw_bcd_digit
    import sw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic inc,
    output bcd_t digit_o
);
    typedef struct packed {
        bcd_t val;
    } dig_t;

    dig_t dg_d, dg_q;

    always_comb begin
        dg_d = dg_q;
        if (inc) begin
            if (dg_q.val == BCD_TOP) begin
                dg_d.val = '0;
            end else begin
                dg_d.val = dg_q.val + 4'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dg_q <= '0;
        end else begin
            dg_q <= dg_d;
        end
    end

    assign digit_o = dg_q.val;

    p_digit_range_r3: assert property (@(posedge clk) disable iff (rst)
        digit_o <= BCD_TOP);
    p_digit_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (inc && digit_o == BCD_TOP) |=> (digit_o == 4'd0));
    p_digit_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(digit_o));
endmodule

// File: rtl/stopwatch_core.sv
module stopwatch_core
    import sw_pkg::*;
#(
    parameter int STAGE1_BITS = 14,
    parameter int STAGE2_BITS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    output logic [3:0] units_o,
    output logic [3:0] tens_o,
    output logic       sec_led_o
);
    // value of stage 2 one step before its top bit rises
    localparam logic [STAGE2_BITS-1:0] S2_PRE_RISE =
        STAGE2_BITS'((64'd1 << (STAGE2_BITS - 1)) - 64'd1);

    typedef struct packed {
        logic u3_prev;
    } edge_t;

    edge_t ed_d, ed_q;

    logic [STAGE1_BITS-1:0] s1_cnt;
    logic [STAGE2_BITS-1:0] s2_cnt;
    logic s1_wrap, s1_msb, s2_wrap, s2_msb;
    logic sec_tick, tens_carry;
    bcd_t units, tens;

    sw_div_stage #(.BITS(STAGE1_BITS)) u_stage1 (
        .clk(clk), .rst(rst), .en(run),
        .cnt_o(s1_cnt), .wrap_o(s1_wrap), .msb_o(s1_msb)
    );

    sw_div_stage #(.BITS(STAGE2_BITS)) u_stage2 (
        .clk(clk), .rst(rst), .en(s1_wrap),
        .cnt_o(s2_cnt), .wrap_o(s2_wrap), .msb_o(s2_msb)
    );

    // inverted level goes low exactly when stage 2's top bit rises
    assign sec_tick = s1_wrap && (s2_cnt == S2_PRE_RISE);

    sw_bcd_digit u_units (
        .clk(clk), .rst(rst), .inc(sec_tick), .digit_o(units)
    );

    always_comb begin
        ed_d = ed_q;
        ed_d.u3_prev = units[3];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ed_q <= '0;
        end else begin
            ed_q <= ed_d;
        end
    end

    assign tens_carry = ed_q.u3_prev && !units[3];

    sw_bcd_digit u_tens (
        .clk(clk), .rst(rst), .inc(tens_carry), .digit_o(tens)
    );

    assign units_o   = units;
    assign tens_o    = tens;
    assign sec_led_o = ~s2_msb;

    p_led_with_tick_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(sec_led_o) |-> !$stable(units_o));
    p_freeze_units_r7: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(units_o));
    p_carry_on_roll_r4: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && units_o == BCD_TOP) |=> ##1 (tens_o != $past(tens_o)));
    p_tens_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !tens_carry |=> $stable(tens_o));
endmodule

// File: tb/stopwatch_core_tb.sv
module stopwatch_core_tb_top;
    localparam int P1 = 2;
    localparam int P2 = 2;
    localparam int PERIOD = 1 << (P1 + P2);
    localparam int HALF = PERIOD / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run = 1'b0;
    logic [3:0] units_o, tens_o;
    logic sec_led_o;

    int n_chk = 0;
    int n_fail = 0;
    int e = 0, tcur = 0, tprev = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    stopwatch_core #(.STAGE1_BITS(P1), .STAGE2_BITS(P2)) dut_i (
        .clk(clk), .rst(rst), .run(run),
        .units_o(units_o), .tens_o(tens_o), .sec_led_o(sec_led_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_units();
        return tcur % 10;
    endfunction

    function automatic int exp_tens();
        return (tprev / 10) % 10;
    endfunction

    // one clock: update the model at the edge, compare at the falling edge
    task automatic step();
        @(posedge clk);
        if (rst) begin
            e = 0; tcur = 0; tprev = 0;
        end else begin
            tprev = tcur;
            if (run) e++;
            tcur = (e + HALF) / PERIOD;
        end
        @(negedge clk);
        check("R2 units", int'(units_o), exp_units());
        check("R4 tens", int'(tens_o), exp_tens());
        check("R6 led", int'(sec_led_o), ((e % PERIOD) >= HALF) ? 0 : 1);
    endtask

    function automatic bit next_is_roll();
        return (exp_units() == 9) && (((e + 1 + HALF) % PERIOD) == 0);
    endfunction

    task automatic t_reset();
        rst = 1'b1; run = 1'b1;
        step(); step();
        check("R1 units", int'(units_o), 0);
        check("R1 tens", int'(tens_o), 0);
        check("R1 led", int'(sec_led_o), 1);
        rst = 1'b0;
    endtask

    task automatic t_first_tick();
        run = 1'b1;
        for (int i = 0; i < HALF - 1; i++) step();
        check("R2 before first tick", int'(units_o), 0);
        step();
        check("R2 first tick", int'(units_o), 1);
        check("R6 led low at tick", int'(sec_led_o), 0);
        for (int i = 0; i < PERIOD; i++) step();
        check("R2 second tick", int'(units_o), 2);
    endtask

    task automatic t_units_roll();
        run = 1'b1;
        while (!next_is_roll()) step();
        step();
        check("R3 units roll", int'(units_o), 0);
        check("R4 tens not yet", int'(tens_o), 0);
        step();
        check("R4 tens after roll", int'(tens_o), 1);
    endtask

    task automatic t_freeze();
        logic [3:0] u;
        logic l;
        u = units_o; l = sec_led_o;
        run = 1'b0;
        for (int i = 0; i < 3 * PERIOD; i++) step();
        check("R7 units frozen", int'(units_o), int'(u));
        check("R7 led frozen", int'(sec_led_o), int'(l));
        run = 1'b1;
    endtask

    task automatic t_carry_run_drop();
        int t0;
        run = 1'b1;
        while (!next_is_roll()) step();
        t0 = int'(tens_o);
        step();
        run = 1'b0;
        step();
        check("R8 carry completes", int'(tens_o), (t0 + 1) % 10);
        check("R8 units held", int'(units_o), 0);
        for (int i = 0; i < PERIOD; i++) step();
        check("R8 tens held", int'(tens_o), (t0 + 1) % 10);
        run = 1'b1;
    endtask

    task automatic t_full_roll();
        run = 1'b1;
        while (!(next_is_roll() && exp_tens() == 9)) step();
        step(); step();
        check("R5 tens roll", int'(tens_o), 0);
        check("R5 units roll", int'(units_o), 0);
        for (int i = 0; i < PERIOD; i++) step();
        check("R5 counting continues", int'(units_o), 1);
    endtask

    task automatic t_mid_reset();
        run = 1'b1;
        for (int i = 0; i < 5 * PERIOD + 3; i++) step();
        rst = 1'b1;
        step();
        check("R1 mid units", int'(units_o), 0);
        check("R1 mid tens", int'(tens_o), 0);
        check("R1 mid led", int'(sec_led_o), 1);
        rst = 1'b0;
        for (int i = 0; i < HALF; i++) step();
        check("R1 restart timing", int'(units_o), 1);
    endtask

    initial begin
        t_reset();
        t_first_tick();
        t_units_roll();
        t_freeze();
        t_carry_run_drop();
        t_full_roll();
        t_mid_reset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule